// File: doc/BRIEF.md
# Single Internal Bus Datapath

This block is the register and transfer fabric of a small processor. The program counter, the memory address and memory data registers, the instruction register, a file of general-purpose registers and the two scratch registers Y and Z all exchange values over one shared internal bus. The block holds no sequencer and decodes nothing. An external control unit drives a vector of enable lines every clock cycle, and the datapath carries out exactly the transfers those lines name.

Each cycle at most one source places its value on the bus. Any number of destinations can capture that value at the next rising clock edge. The ALU always takes the bus as its first operand. Its second operand is either a fixed increment constant or register Y, and the only place its result can go is register Z. The memory address register feeds the external address port. The memory data register can be loaded from the external read-data port or from the bus. It can drive the bus, and its contents are always present on the external write-data port.

A typical instruction fetch takes four steps. First, the program counter drives the bus while MAR loads and Z captures the counter plus the constant. Next, Z drives the bus into the program counter and Y. Then, once memory has answered, MDR loads from the read-data port. Finally, MDR drives the bus into the instruction register.

Top module: `sbus_datapath`

## Requirements
- R1: An active-low asynchronous reset clears every register: PC, MAR, MDR, IR, Y, Z and all general-purpose registers read zero afterwards.
- R2: The bus carries the value of the single source whose drive enable is high. Every destination whose load enable is high in that cycle captures the same value at the next rising edge. Controllers must never raise two drive enables together.
- R3: A register with its load enable high takes the bus value at the rising edge. With the load enable low, the register keeps its value whatever the bus carries.
- R4: When `opnd_sel_const` is 1, the ALU's second operand is the constant INC_CONST (4 by default). When it is 0, the second operand is register Y.
- R5: Z loads the ALU result only in a cycle with `z_ld` high, and it otherwise holds. Z reaches the bus only while `z_drv` is high.
- R6: `alu_op` encodings, with A the bus and B the second operand, are: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 A<<B[4:0], 6 logical A>>B[4:0], 7 arithmetic A>>>B[4:0], 8 A, 9 B, 10 ~A, 11 signed A<B (1 or 0), 12 unsigned A<B (1 or 0), 13 ~(A&B), 14 ~(A|B), 15 ~(A^B).
- R7: MAR loads from the bus, and `ext_addr` shows MAR's contents at all times.
- R8: MDR loads from `ext_rdata` when `mdr_ld_ext` is high and from the bus when `mdr_ld_bus` is high. When both are high in the same cycle, the external value wins.
- R9: `ext_wdata` always shows MDR, and `ext_wr` is high exactly in cycles where `mdr_wr` is high. MDR drives the bus while `mdr_drv` is high.
- R10: The instruction register loads from the bus on `ir_ld`, and its contents appear on `ir_word`.
- R11: When no drive enable is high, the bus reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpr_ld | input | NREG | Per-register load-from-bus enables |
| gpr_drv | input | NREG | Per-register drive-bus enables |
| pc_ld | input | 1 | Program counter load from bus |
| pc_drv | input | 1 | Program counter drives bus |
| mar_ld | input | 1 | Address register load from bus |
| mdr_ld_bus | input | 1 | Data register load from bus |
| mdr_ld_ext | input | 1 | Data register load from ext_rdata |
| mdr_drv | input | 1 | Data register drives bus |
| mdr_wr | input | 1 | Request to write MDR to memory |
| ir_ld | input | 1 | Instruction register load from bus |
| y_ld | input | 1 | Y load from bus |
| z_ld | input | 1 | Z load from ALU result |
| z_drv | input | 1 | Z drives bus |
| opnd_sel_const | input | 1 | 1: constant operand, 0: Y operand |
| alu_op | input | 4 | ALU operation code |
| ext_addr | output | DATA_W | Memory address (MAR) |
| ext_rdata | input | DATA_W | Memory read data |
| ext_wdata | output | DATA_W | Memory write data (MDR) |
| ext_wr | output | 1 | Memory write strobe |
| ir_word | output | DATA_W | Instruction register toward decode |

## Verification
The bench builds the block with its defaults: a 32-bit word, eight general-purpose registers and an increment constant of 4. These values let it touch every register in the file and reach shift amounts up to 31. They also let it replay a full fetch, in which the program counter advances by exactly 4. Register contents are observed only through the ports, by routing them over the bus into MAR and reading `ext_addr`.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ASR  = 4'd7,
        OP_PA   = 4'd8,
        OP_PB   = 4'd9,
        OP_NOTA = 4'd10,
        OP_SLT  = 4'd11,
        OP_SLTU = 4'd12,
        OP_NAND = 4'd13,
        OP_NOR  = 4'd14,
        OP_XNOR = 4'd15
    } alu_op_e;

endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/sbus_gpr_file.sv
module sbus_gpr_file #(
    parameter int W    = 32,
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        ld,
    input  logic [W-1:0]           bus,
    output logic [NREG-1:0][W-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        sbus_reg #(.W(W)) u_r (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (ld[g]),
            .d    (bus),
            .q    (q[g])
        );
    end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);
    // AND-OR combine: zero when idle, defined only for one driver
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            if (en[i]) bus = bus | src[i];
        end
    end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] sh;
    assign sh = b[SH_W-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << sh;
            OP_SHR:  y = a >> sh;
            OP_ASR:  y = W'($signed(a) >>> sh);
            OP_PA:   y = a;
            OP_PB:   y = b;
            OP_NOTA: y = ~a;
            OP_SLT:  y = W'($signed(a) < $signed(b));
            OP_SLTU: y = W'(a < b);
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NREG      = 8,
    parameter int INC_CONST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   gpr_ld,
    input  logic [NREG-1:0]   gpr_drv,
    input  logic              pc_ld,
    input  logic              pc_drv,
    input  logic              mar_ld,
    input  logic              mdr_ld_bus,
    input  logic              mdr_ld_ext,
    input  logic              mdr_drv,
    input  logic              mdr_wr,
    input  logic              ir_ld,
    input  logic              y_ld,
    input  logic              z_ld,
    input  logic              z_drv,
    input  logic              opnd_sel_const,
    input  logic [3:0]        alu_op,
    output logic [DATA_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_wr,
    output logic [DATA_W-1:0] ir_word
);
    localparam int NSRC = NREG + 3;

    logic [DATA_W-1:0]             bus_w;
    logic [NREG-1:0][DATA_W-1:0]   gpr_q;
    logic [DATA_W-1:0]             pc_q, y_q, z_q, mdr_q, alu_y, opnd_b;
    logic [NSRC-1:0]               drv_en;
    logic [NSRC-1:0][DATA_W-1:0]   drv_src;

    // source order: z, mdr, pc, then general registers
    assign drv_en = {gpr_drv, pc_drv, mdr_drv, z_drv};

    always_comb begin
        drv_src[0] = z_q;
        drv_src[1] = mdr_q;
        drv_src[2] = pc_q;
        for (int i = 0; i < NREG; i++) drv_src[i+3] = gpr_q[i];
    end

    sbus_bus_mux #(.W(DATA_W), .N(NSRC)) u_bus (
        .en (drv_en),
        .src(drv_src),
        .bus(bus_w)
    );

    sbus_gpr_file #(.W(DATA_W), .NREG(NREG)) u_gpr (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (gpr_ld),
        .bus  (bus_w),
        .q    (gpr_q)
    );

    sbus_reg #(.W(DATA_W)) u_pc  (.clk(clk), .rst_n(rst_n), .ld(pc_ld),  .d(bus_w), .q(pc_q));
    sbus_reg #(.W(DATA_W)) u_mar (.clk(clk), .rst_n(rst_n), .ld(mar_ld), .d(bus_w), .q(ext_addr));
    sbus_reg #(.W(DATA_W)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(ir_ld),  .d(bus_w), .q(ir_word));
    sbus_reg #(.W(DATA_W)) u_y   (.clk(clk), .rst_n(rst_n), .ld(y_ld),   .d(bus_w), .q(y_q));
    sbus_reg #(.W(DATA_W)) u_z   (.clk(clk), .rst_n(rst_n), .ld(z_ld),   .d(alu_y), .q(z_q));

    // data register: external load has priority over bus load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mdr_q <= '0;
        else if (mdr_ld_ext) mdr_q <= ext_rdata;
        else if (mdr_ld_bus) mdr_q <= bus_w;
    end

    assign opnd_b = opnd_sel_const ? DATA_W'(INC_CONST) : y_q;

    sbus_alu #(.W(DATA_W)) u_alu (
        .op(alu_op_e'(alu_op)),
        .a (bus_w),
        .b (opnd_b),
        .y (alu_y)
    );

    assign ext_wdata = mdr_q;
    assign ext_wr    = mdr_wr;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int DATA_W    = 32,
    parameter int NSRC      = 11,
    parameter int INC_CONST = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   drv_en,
    input logic [DATA_W-1:0] bus_w,
    input logic              pc_ld,
    input logic              mar_ld,
    input logic              ir_ld,
    input logic              z_ld,
    input logic              mdr_ld_ext,
    input logic              opnd_sel_const,
    input logic [3:0]        alu_op,
    input logic [DATA_W-1:0] ext_rdata,
    input logic [DATA_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ir_word,
    input logic [DATA_W-1:0] pc_q,
    input logic [DATA_W-1:0] z_q,
    input logic [DATA_W-1:0] mdr_q
);
    p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));

    p_pc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |=> pc_q == $past(bus_w));

    p_const_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (z_ld && opnd_sel_const && alu_op == 4'd0) |=>
            z_q == $past(bus_w) + DATA_W'(INC_CONST));

    p_z_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !z_ld |=> $stable(z_q));

    p_mar_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ld |=> ext_addr == $past(bus_w));

    p_mdr_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mdr_ld_ext |=> mdr_q == $past(ext_rdata));

    p_ir_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |=> ir_word == $past(bus_w));

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en == '0) |-> (bus_w == '0));
endmodule

bind sbus_datapath sbus_datapath_chk #(
    .DATA_W(DATA_W), .NSRC(NSRC), .INC_CONST(INC_CONST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .bus_w(bus_w),
    .pc_ld(pc_ld), .mar_ld(mar_ld), .ir_ld(ir_ld), .z_ld(z_ld),
    .mdr_ld_ext(mdr_ld_ext), .opnd_sel_const(opnd_sel_const),
    .alu_op(alu_op), .ext_rdata(ext_rdata), .ext_addr(ext_addr),
    .ir_word(ir_word), .pc_q(pc_q), .z_q(z_q), .mdr_q(mdr_q)
);

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
    localparam int W = 32;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0] gpr_ld, gpr_drv;
    logic pc_ld, pc_drv, mar_ld, mdr_ld_bus, mdr_ld_ext, mdr_drv, mdr_wr;
    logic ir_ld, y_ld, z_ld, z_drv, opnd_sel_const;
    logic [3:0] alu_op;
    logic [W-1:0] ext_addr, ext_rdata, ext_wdata, ir_word;
    logic ext_wr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sbus_datapath #(.DATA_W(W), .NREG(NR), .INC_CONST(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .gpr_ld(gpr_ld), .gpr_drv(gpr_drv),
        .pc_ld(pc_ld), .pc_drv(pc_drv), .mar_ld(mar_ld),
        .mdr_ld_bus(mdr_ld_bus), .mdr_ld_ext(mdr_ld_ext), .mdr_drv(mdr_drv),
        .mdr_wr(mdr_wr), .ir_ld(ir_ld), .y_ld(y_ld), .z_ld(z_ld),
        .z_drv(z_drv), .opnd_sel_const(opnd_sel_const), .alu_op(alu_op),
        .ext_addr(ext_addr), .ext_rdata(ext_rdata), .ext_wdata(ext_wdata),
        .ext_wr(ext_wr), .ir_word(ir_word)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        gpr_ld = '0; gpr_drv = '0; pc_ld = 0; pc_drv = 0; mar_ld = 0;
        mdr_ld_bus = 0; mdr_ld_ext = 0; mdr_drv = 0; mdr_wr = 0; ir_ld = 0;
        y_ld = 0; z_ld = 0; z_drv = 0; opnd_sel_const = 0; alu_op = 4'd0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    // value -> MDR via external port, then MDR -> destination enables set by caller
    task automatic put_mdr(logic [W-1:0] v);
        ext_rdata = v; mdr_ld_ext = 1; step();
    endtask

    task automatic load_gpr(int idx, logic [W-1:0] v);
        put_mdr(v);
        mdr_drv = 1; gpr_ld[idx] = 1; step();
    endtask

    task automatic load_y(logic [W-1:0] v);
        put_mdr(v);
        mdr_drv = 1; y_ld = 1; step();
    endtask

    task automatic rd_gpr(int idx, output logic [W-1:0] v);
        gpr_drv[idx] = 1; mar_ld = 1; step();
        v = ext_addr;
    endtask

    task automatic rd_z(output logic [W-1:0] v);
        z_drv = 1; mar_ld = 1; step();
        v = ext_addr;
    endtask

    function automatic logic [W-1:0] alu_ref(int op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            7: return W'($signed(a) >>> b[4:0]);
            8: return a;
            9: return b;
            10: return ~a;
            11: return ($signed(a) < $signed(b)) ? 1 : 0;
            12: return (a < b) ? 1 : 0;
            13: return ~(a & b);
            14: return ~(a | b);
            default: return ~(a ^ b);
        endcase
    endfunction

    task automatic t_reset();
        logic [W-1:0] v;
        chk("R1 mar", ext_addr, '0);
        chk("R1 ir", ir_word, '0);
        chk("R1 mdr", ext_wdata, '0);
        chk("R1 wr", {31'b0, ext_wr}, '0);
        for (int i = 0; i < NR; i++) begin
            rd_gpr(i, v);
            chk("R1 gpr", v, '0);
        end
        rd_z(v);
        chk("R1 z", v, '0);
        pc_drv = 1; mar_ld = 1; step();
        chk("R1 pc", ext_addr, '0);
        // Y reset: ADD with idle bus and Y operand gives Y
        z_ld = 1; alu_op = 4'd0; step();
        rd_z(v);
        chk("R1 y", v, '0);
    endtask

    task automatic t_fetch();
        logic [W-1:0] v;
        put_mdr(32'h0000_0100);
        mdr_drv = 1; pc_ld = 1; step();
        pc_drv = 1; mar_ld = 1; opnd_sel_const = 1; alu_op = 4'd0; z_ld = 1; step();
        chk("R7 fetch addr", ext_addr, 32'h100);
        z_drv = 1; pc_ld = 1; y_ld = 1; step();
        ext_rdata = 32'hCAFE_F00D; mdr_ld_ext = 1; step();
        mdr_drv = 1; ir_ld = 1; step();
        chk("R10 ir", ir_word, 32'hCAFE_F00D);
        pc_drv = 1; mar_ld = 1; step();
        chk("R4 pc+4", ext_addr, 32'h104);
        z_ld = 1; alu_op = 4'd0; step();   // idle bus + Y
        rd_z(v);
        chk("R11 idle bus plus Y", v, 32'h104);
    endtask

    task automatic t_alu();
        logic [W-1:0] av [3] = '{32'h8000_00F3, 32'h0000_0005, 32'hFFFF_FFFE};
        logic [W-1:0] bv [3] = '{32'h0000_0004, 32'h0000_0009, 32'hFFFF_FFFE};
        logic [W-1:0] v;
        for (int p = 0; p < 3; p++) begin
            load_gpr(1, av[p]);
            load_y(bv[p]);
            for (int op = 0; op < 16; op++) begin
                gpr_drv[1] = 1; alu_op = 4'(op); z_ld = 1; step();
                rd_z(v);
                chk($sformatf("R6 op%0d", op), v, alu_ref(op, av[p], bv[p]));
            end
        end
    endtask

    task automatic t_z_hold();
        logic [W-1:0] v;
        load_gpr(2, 32'h1234_5678);
        gpr_drv[2] = 1; alu_op = 4'd8; z_ld = 1; step();
        gpr_drv[2] = 1; alu_op = 4'd10; opnd_sel_const = 1; step();
        rd_z(v);
        chk("R5 z hold", v, 32'h1234_5678);
    endtask

    task automatic t_mdr();
        logic [W-1:0] v;
        load_gpr(3, 32'h0BAD_BEEF);
        gpr_drv[3] = 1; mdr_ld_bus = 1; step();
        chk("R8 mdr from bus", ext_wdata, 32'h0BAD_BEEF);
        gpr_drv[3] = 1; mdr_ld_bus = 1; ext_rdata = 32'h5555_AAAA; mdr_ld_ext = 1; step();
        chk("R8 ext priority", ext_wdata, 32'h5555_AAAA);
        mdr_wr = 1; #1;
        chk("R9 wr strobe", {31'b0, ext_wr}, 32'd1);
        step();
        chk("R9 wr drop", {31'b0, ext_wr}, 32'd0);
        mdr_drv = 1; gpr_ld[4] = 1; step();
        rd_gpr(4, v);
        chk("R9 mdr drives bus", v, 32'h5555_AAAA);
    endtask

    task automatic t_multi();
        logic [W-1:0] v;
        load_gpr(5, 32'h7777_0001);
        gpr_drv[5] = 1; mar_ld = 1; ir_ld = 1; gpr_ld[6] = 1; pc_ld = 1; step();
        chk("R2 mar", ext_addr, 32'h7777_0001);
        chk("R2 ir", ir_word, 32'h7777_0001);
        rd_gpr(6, v);
        chk("R2 gpr6", v, 32'h7777_0001);
        pc_drv = 1; mar_ld = 1; step();
        chk("R2 pc", ext_addr, 32'h7777_0001);
        // R3 hold: bus carries other data, r5 not loaded
        load_gpr(7, 32'h0F0F_0F0F);
        gpr_drv[7] = 1; step();
        rd_gpr(5, v);
        chk("R3 hold", v, 32'h7777_0001);
    endtask

    initial begin
        clr();
        ext_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fetch();
        t_alu();
        t_z_hold();
        t_mdr();
        t_multi();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule